// File: doc/BRIEF.md
# Two-Stage Nested Priority Event Controller

This block gathers interrupt lines from many peripherals and turns them into a single prioritized vector request for a processor core. A routing stage sits at the front. It gates each peripheral line with its own enable bit and reports which enabled lines are high. It then steers each line to one of nine general-purpose priority levels through a programmable 4-bit assignment field.

A core stage follows. It watches the sixteen level lines for rising edges. Four of these lines are fixed: emulation, reset, NMI and exception. Nine are general-purpose levels, numbered 7 to 15. Levels 4 to 6 are reserved and never fire. The core stage holds each detected edge in a latch bit and gates the latch with a per-level enable. It announces the most urgent eligible level whenever that level outranks everything currently in service.

An announced level is accepted on the next clock edge. On that edge its latch bit moves into the pending set. The pending set records every level that is being serviced or has been interrupted. A return strobe retires the most urgent pending level. Software reaches the controller through a word-addressed write/read port, and writes take effect only while the supervisor input is high.

Top module: `evt_ctrl`

## Requirements
- R1: After reset the following values hold. The latch (word 0), pending (word 2), level-enable (word 1) and source-enable (word 4) registers read 0. The global enable (word 3, bit 0) reads 1. Source i is assigned field value i mod 9, so assignment word 8 reads 0x76543210 and word 9 reads 0x00002108. No vector is requested.
- R2: A rising edge on an enabled level sets latch bit L two clock edges after the input rises. During that same cycle the block requests a vector with `vec_req`=1 and `vec_lvl`=L. On the third edge pending bit L sets and latch bit L clears.
- R3: A level whose enable bit (word 1, bit L) is 0 stays latched and is never requested. Once software sets its enable bit, the level is requested.
- R4: A lower level number means higher priority. A request is made only for a level numbered below the lowest set pending bit. Lower-priority levels stay pending while a higher one is serviced.
- R5: A one-cycle `ret_stb` clears the lowest-numbered set pending bit. A latched level that now outranks the remaining pending bits is requested in the cycle that follows the strobe.
- R6: Writing a 1 to a latch bit through word 0 clears that bit. The clear takes effect only if `sup`=1 and the bit's enable in word 1 is 0. A rising edge on the same level in the same cycle wins over the clear.
- R7: When the global enable is 0, levels 7 to 15 are held back without changing word 1. Levels 0 to 2 ignore both the enables and the global enable. Level 3 obeys only its own enable bit.
- R8: Source i drives the routing stage only when bit i of word 4 is 1. The status register (word 5) reads the source inputs ANDed with word 4.
- R9: The 4-bit field for source i sits in word 8+i/8, at bits 4*(i mod 8) and up. The field routes the source to level 7+field. A field value above 8 routes the source nowhere.
- R10: A new rising edge on a level that is already pending sets its latch bit again. That latched level is requested once the pending bit has been retired.
- R11: A register write while `sup`=0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup | input | 1 | Supervisor mode qualifier for writes |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| src_irq | input | 12 | Peripheral interrupt lines |
| emu_evt | input | 1 | Emulation event (level 0) |
| rst_evt | input | 1 | Reset event (level 1) |
| nmi_evt | input | 1 | Non-maskable event (level 2) |
| exc_evt | input | 1 | Exception event (level 3) |
| ret_stb | input | 1 | Return from the current service level |
| vec_req | output | 1 | Vector request, accepted on the next edge |
| vec_lvl | output | 4 | Level being requested |

## Verification
Two pairs of events can collide in a single cycle. The first is a software latch clear landing on the same edge that latches a new rising edge for that level. The bench provokes this by raising the source one edge before it issues the clear write, so both hit the same edge. It expects the latch bit to survive, and it expects a later clear with no edge to remove the bit. The second is a request for a level that is already pending. Here the bench expects the re-latched bit to wait quietly until a return strobe retires the pending bit, and it expects the request in the cycle that follows the strobe.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int NLVL   = 16;
  localparam int LW     = 4;
  localparam int LV_EMU = 0;
  localparam int LV_RST = 1;
  localparam int LV_NMI = 2;
  localparam int LV_EXC = 3;
  localparam int GP_LO  = 7;
  localparam int NGP    = 9;
  localparam int FW     = 4;

  localparam int A_LATCH = 0;
  localparam int A_MASK  = 1;
  localparam int A_PEND  = 2;
  localparam int A_GEN   = 3;
  localparam int A_SMASK = 4;
  localparam int A_STAT  = 5;
  localparam int A_ASG   = 8;

  // index of the most urgent set bit, NLVL when none is set
  function automatic logic [LW:0] low_idx(input logic [NLVL-1:0] v);
    logic [LW:0] r;
    r = (LW+1)'(NLVL);
    for (int i = NLVL-1; i >= 0; i--) begin
      if (v[i]) r = (LW+1)'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/evt_rst_sync.sv
module evt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      s1_q    <= 1'b1;
      rst_s_n <= s1_q;
    end
  end
endmodule

// File: rtl/evt_edge_det.sv
module evt_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign rise = s1_q & ~s2_q;
endmodule

// File: rtl/evt_sys_route.sv
module evt_sys_route
  import evt_pkg::*;
#(
  parameter int NSRC = 12
) (
  input  logic [NSRC-1:0]    src,
  input  logic [NSRC-1:0]    smask,
  input  logic [NSRC*FW-1:0] asg,
  output logic [NGP-1:0]     gp,
  output logic [NSRC-1:0]    status
);
  always_comb begin
    status = src & smask;
    gp     = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (status[i] && (asg[i*FW +: FW] < FW'(NGP))) begin
        gp[asg[i*FW +: FW]] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/evt_core.sv
module evt_core
  import evt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL-1:0] lvl_raw,
  input  logic [NLVL-1:0] mask,
  input  logic [NLVL-1:0] clr_req,
  input  logic            gen,
  input  logic            ret_stb,
  output logic [NLVL-1:0] latch_q,
  output logic [NLVL-1:0] pend_q,
  output logic            vec_req,
  output logic [LW-1:0]   vec_lvl
);
  logic [NLVL-1:0] rise, en_eff, elig, acc_oh, ret_oh, latch_n, pend_n;
  logic [LW:0]     cand, cur;

  for (genvar g = 0; g < NLVL; g++) begin : g_ed
    evt_edge_det u_ed (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (lvl_raw[g]),
      .rise (rise[g])
    );
  end

  always_comb begin
    for (int i = 0; i < NLVL; i++) begin
      if (i <= LV_NMI)      en_eff[i] = 1'b1;
      else if (i == LV_EXC) en_eff[i] = mask[i];
      else if (i >= GP_LO)  en_eff[i] = mask[i] & gen;
      else                  en_eff[i] = 1'b0;
    end
    elig    = latch_q & en_eff;
    cand    = low_idx(elig);
    cur     = low_idx(pend_q);
    vec_req = (cand < cur);
    vec_lvl = cand[LW-1:0];
    acc_oh  = vec_req ? (NLVL'(1) << cand[LW-1:0]) : '0;
    ret_oh  = (ret_stb && (cur < (LW+1)'(NLVL))) ? (NLVL'(1) << cur[LW-1:0]) : '0;
    latch_n = (latch_q & ~clr_req & ~acc_oh) | rise;
    pend_n  = (pend_q & ~ret_oh) | acc_oh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      pend_q  <= '0;
    end else begin
      latch_q <= latch_n;
      pend_q  <= pend_n;
    end
  end
endmodule

// File: rtl/evt_ctrl.sv
module evt_ctrl
  import evt_pkg::*;
#(
  parameter int NSRC = 12,
  parameter int AW   = 4,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sup,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] src_irq,
  input  logic            emu_evt,
  input  logic            rst_evt,
  input  logic            nmi_evt,
  input  logic            exc_evt,
  input  logic            ret_stb,
  output logic            vec_req,
  output logic [LW-1:0]   vec_lvl
);
  localparam int NAW = (NSRC*FW + DW - 1) / DW;
  localparam int FPW = DW / FW;

  logic                 rst_s_n;
  logic                 wr_ok;
  logic [NLVL-1:0]      mask_q, mask_n, clr_req, latch_w, pend_w, lvl_raw;
  logic                 gen_q, gen_n;
  logic [NSRC-1:0]      smask_q, smask_n, status;
  logic [NSRC*FW-1:0]   asg_q, asg_n;
  logic [NAW*DW-1:0]    asg_pad;
  logic [NGP-1:0]       gp;
  logic [AW-1:0]        aidx;

  evt_rst_sync u_rs (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_s_n(rst_s_n)
  );

  evt_sys_route #(.NSRC(NSRC)) u_route (
    .src   (src_irq),
    .smask (smask_q),
    .asg   (asg_q),
    .gp    (gp),
    .status(status)
  );

  assign lvl_raw = {gp, 3'b000, exc_evt, nmi_evt, rst_evt, emu_evt};
  assign wr_ok   = bus_wr & sup;
  assign clr_req = (wr_ok && bus_addr == AW'(A_LATCH)) ? (bus_wdata[NLVL-1:0] & ~mask_q) : '0;

  evt_core u_core (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .lvl_raw(lvl_raw),
    .mask   (mask_q),
    .clr_req(clr_req),
    .gen    (gen_q),
    .ret_stb(ret_stb),
    .latch_q(latch_w),
    .pend_q (pend_w),
    .vec_req(vec_req),
    .vec_lvl(vec_lvl)
  );

  // next-state of the programmable registers
  always_comb begin
    mask_n  = mask_q;
    gen_n   = gen_q;
    smask_n = smask_q;
    asg_n   = asg_q;
    if (wr_ok) begin
      if (bus_addr == AW'(A_MASK))  mask_n  = bus_wdata[NLVL-1:0];
      if (bus_addr == AW'(A_GEN))   gen_n   = bus_wdata[0];
      if (bus_addr == AW'(A_SMASK)) smask_n = bus_wdata[NSRC-1:0];
      for (int i = 0; i < NSRC; i++) begin
        if (bus_addr == AW'(A_ASG + i / FPW)) begin
          asg_n[i*FW +: FW] = bus_wdata[(i % FPW)*FW +: FW];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      mask_q  <= '0;
      gen_q   <= 1'b1;
      smask_q <= '0;
      for (int i = 0; i < NSRC; i++) asg_q[i*FW +: FW] <= FW'(i % NGP);
    end else begin
      mask_q  <= mask_n;
      gen_q   <= gen_n;
      smask_q <= smask_n;
      asg_q   <= asg_n;
    end
  end

  assign asg_pad = (NAW*DW)'(asg_q);
  assign aidx    = bus_addr - AW'(A_ASG);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(A_LATCH): bus_rdata = DW'(latch_w);
      AW'(A_MASK):  bus_rdata = DW'(mask_q);
      AW'(A_PEND):  bus_rdata = DW'(pend_w);
      AW'(A_GEN):   bus_rdata = DW'(gen_q);
      AW'(A_SMASK): bus_rdata = DW'(smask_q);
      AW'(A_STAT):  bus_rdata = DW'(status);
      default: begin
        if (bus_addr >= AW'(A_ASG) && int'(aidx) < NAW) bus_rdata = asg_pad[int'(aidx)*DW +: DW];
      end
    endcase
  end
endmodule

// File: rtl/evt_ctrl_chk.sv
module evt_ctrl_chk
  import evt_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [NLVL-1:0] pend,
  input logic            vec_req,
  input logic [LW-1:0]   vec_lvl,
  input logic            ret_stb,
  input logic [NLVL-1:0] mask,
  input logic            gen
);
  // R4
  outrank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> ((pend & ((NLVL'(1) << vec_lvl) | ((NLVL'(1) << vec_lvl) - NLVL'(1)))) == '0));

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |=> pend[$past(vec_lvl)]);

  // R7
  gp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && vec_lvl >= LW'(GP_LO)) |-> (mask[vec_lvl] && gen));

  // R3
  exc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && vec_lvl == LW'(LV_EXC)) |-> mask[LV_EXC]);

  // R5
  ret_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_stb && !vec_req && pend != '0) |=> ($countones(pend) == $countones($past(pend)) - 1));

  // R4
  one_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(pend & ~$past(pend)) <= 1));

  // R1
  reserved_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend[6:4] == 3'b000);
endmodule

bind evt_ctrl evt_ctrl_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .pend   (pend_w),
  .vec_req(vec_req),
  .vec_lvl(vec_lvl),
  .ret_stb(ret_stb),
  .mask   (mask_q),
  .gen    (gen_q)
);

// File: tb/evt_ctrl_bench.sv
module evt_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int NS    = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sup = 1'b0, bus_wr = 1'b0, ret_stb = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NS-1:0] src_irq = '0;
  logic        emu_evt = 1'b0, rst_evt = 1'b0, nmi_evt = 1'b0, exc_evt = 1'b0;
  logic        vec_req;
  logic [3:0]  vec_lvl;
  int          total = 0, bad = 0;
  logic [3:0]  fld [NS];

  evt_ctrl u_evt_ctrl (.*);

  always #(CLK_P/2) clk = ~clk;

  initial begin
    #(CLK_P*100000);
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d, logic s = 1'b1);
    bus_addr = a; bus_wdata = d; sup = s; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0; sup = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic chk_reg(string req, logic [3:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic chk_vec(string req, logic r, logic [3:0] l);
    check(req, {27'd0, vec_req, vec_lvl}, {27'd0, r, r ? l : vec_lvl});
  endtask

  task automatic ret();
    ret_stb = 1'b1; step(); ret_stb = 1'b0;
  endtask

  function automatic logic [31:0] word_of(int w);
    logic [31:0] r = '0;
    for (int k = 0; k < 8; k++) if (w*8 + k < NS) r[k*4 +: 4] = fld[w*8 + k];
    return r;
  endfunction

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < NS; i++) fld[i] = 4'(i % 9);
    step(3); rst_n = 1'b1; step(4);

    // R1 reset state
    chk_reg("R1 latch", 0, 0); chk_reg("R1 mask", 1, 0); chk_reg("R1 pend", 2, 0);
    chk_reg("R1 gen", 3, 1); chk_reg("R1 smask", 4, 0);
    chk_reg("R1 asg0", 8, 32'h76543210); chk_reg("R1 asg1", 9, 32'h00002108);
    chk_vec("R1 vec", 1'b0, 4'd0);

    // R11 unprivileged write ignored
    wr(1, 32'hFF88, 1'b0);
    chk_reg("R11 mask", 1, 0);

    wr(4, 32'hFFF); wr(1, 32'hFF88);

    // R2 latency
    src_irq[0] = 1'b1; step();
    chk_reg("R2 latch early", 0, 0);
    step();
    chk_reg("R2 latch", 0, 32'h80); chk_vec("R2 vec", 1'b1, 4'd7);
    step();
    chk_reg("R2 pend", 2, 32'h80); chk_reg("R2 latch clr", 0, 0);

    // R4 nesting
    src_irq[1] = 1'b1; step(2);
    chk_reg("R4 low latched", 0, 32'h100); chk_vec("R4 no req", 1'b0, 4'd0);
    nmi_evt = 1'b1; step(2);
    chk_vec("R4 nmi req", 1'b1, 4'd2);
    step();
    chk_reg("R4 nested pend", 2, 32'h84);

    // R5 return
    ret(); chk_reg("R5 ret1", 2, 32'h80);
    ret(); chk_reg("R5 ret2", 2, 0); chk_vec("R5 follow req", 1'b1, 4'd8);
    step(); chk_reg("R5 pend8", 2, 32'h100);
    ret();
    src_irq = '0; nmi_evt = 1'b0; step(2);

    // R3 masked level stays latched
    wr(1, 32'hFD88);
    src_irq[2] = 1'b1; step(3);
    chk_reg("R3 latched", 0, 32'h200); chk_reg("R3 no pend", 2, 0); chk_vec("R3 no req", 1'b0, 4'd0);
    wr(1, 32'hFF88);
    chk_vec("R3 unmask req", 1'b1, 4'd9);
    step(); chk_reg("R3 pend", 2, 32'h200);
    ret(); src_irq[2] = 1'b0; step(2);

    // R6 guarded latch clear
    wr(1, 32'hFB88);
    src_irq[3] = 1'b1; step(2);
    chk_reg("R6 latched", 0, 32'h400);
    wr(0, 32'h400, 1'b0); chk_reg("R6 unpriv clr", 0, 32'h400);
    wr(0, 32'h400, 1'b1); chk_reg("R6 clr", 0, 0);
    src_irq[3] = 1'b0; step(2);

    // R7 global enable
    wr(3, 0); wr(1, 32'hFF88);
    src_irq[3] = 1'b1; step(2);
    chk_reg("R7 held", 0, 32'h400); chk_vec("R7 no req", 1'b0, 4'd0);
    wr(0, 32'h400, 1'b1); chk_reg("R6 enabled no clr", 0, 32'h400);
    chk_reg("R7 mask kept", 1, 32'hFF88);
    nmi_evt = 1'b1; step(2);
    chk_vec("R7 nmi bypass", 1'b1, 4'd2);
    step(); ret(); nmi_evt = 1'b0;
    wr(3, 1);
    chk_vec("R7 gen on", 1'b1, 4'd10);
    step(); ret(); src_irq[3] = 1'b0; step(2);
    wr(1, 32'hFF80);
    exc_evt = 1'b1; step(3);
    chk_reg("R7 exc held", 0, 32'h8); chk_vec("R7 exc no req", 1'b0, 4'd0);
    wr(1, 32'hFF88);
    chk_vec("R7 exc req", 1'b1, 4'd3);
    step(); ret(); exc_evt = 1'b0;
    wr(1, 32'h0);
    emu_evt = 1'b1; step(2);
    chk_vec("R7 emu bypass", 1'b1, 4'd0);
    step(); ret(); emu_evt = 1'b0; wr(1, 32'hFF88); step(2);

    // R8 source enable and status
    wr(4, 32'hFEF);
    src_irq[4] = 1'b1; step();
    chk_reg("R8 status off", 5, 0);
    step(2); chk_reg("R8 no latch", 0, 0);
    wr(4, 32'hFFF);
    chk_reg("R8 status on", 5, 32'h10);
    step(2); chk_reg("R8 latch", 0, 32'h800);
    step(); ret(); src_irq[4] = 1'b0; step(2);

    // R6 same-cycle edge and clear
    wr(1, 32'hF788);
    src_irq[4] = 1'b1; step(2);
    src_irq[4] = 1'b0; step(2);
    src_irq[4] = 1'b1; step();
    wr(0, 32'h800, 1'b1);
    chk_reg("R6 edge wins", 0, 32'h800);
    wr(0, 32'h800, 1'b1);
    chk_reg("R6 later clr", 0, 0);
    src_irq[4] = 1'b0; wr(1, 32'hFF88); step(2);

    // R9 assignment
    wr(8, 32'h76C43210);
    src_irq[5] = 1'b1; step(3);
    chk_reg("R9 unmapped latch", 0, 0); chk_reg("R9 unmapped pend", 2, 0);
    src_irq[5] = 1'b0; step(2);
    wr(8, 32'h76843210);
    src_irq[5] = 1'b1; step(2);
    chk_vec("R9 lvl15", 1'b1, 4'd15);
    step(); chk_reg("R9 pend", 2, 32'h8000);
    ret(); src_irq[5] = 1'b0;
    wr(8, 32'h76543210); step(2);

    // R10 requeue
    src_irq[0] = 1'b1; step(3);
    chk_reg("R10 pend", 2, 32'h80);
    src_irq[0] = 1'b0; step(); src_irq[0] = 1'b1; step(2);
    chk_reg("R10 relatch", 0, 32'h80); chk_vec("R10 wait", 1'b0, 4'd0);
    ret();
    chk_vec("R10 req after ret", 1'b1, 4'd7);
    step(); chk_reg("R10 pend again", 2, 32'h80); chk_reg("R10 latch clr", 0, 0);
    ret(); src_irq[0] = 1'b0; step(2);

    // random routing, R8 and R9
    for (int it = 0; it < 40; it++) begin
      int s, f;
      logic sm;
      logic [31:0] exp;
      s = int'($urandom % NS);
      f = int'($urandom % 12);
      sm = ($urandom % 4) != 0;
      fld[s] = 4'(f);
      wr(4'(8 + s / 8), word_of(s / 8));
      wr(4, sm ? 32'hFFF : (32'hFFF & ~(32'd1 << s)));
      src_irq[s] = 1'b1; step(3);
      exp = (sm && f <= 8) ? (32'd1 << (7 + f)) : 32'd0;
      chk_reg("R9 random route", 2, exp);
      if (exp != 0) ret();
      src_irq[s] = 1'b0; step(2);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule